// File: doc/BRIEF.md
# Programmable Burst Pulse Generator

This block produces a gated pulse sequence from one synchronous clock. Once its selected run condition turns true, it waits a startup interval, then emits pulses of a set width with a set gap between them. It stops once a pulse limit is reached, or starts the sequence over when loop mode is on. The pulse train can be shifted later by a fixed number of cycles. One of several inputs is chosen as the run condition, and that input can be read either as an enable or as a veto. Another selectable input can cut a pulse short. A hold input keeps the output low.

The same engine covers three uses. A long gate uses a wide pulse in loop mode. A shutter window has its width trimmed by the cut-short input. A trigger train uses width 1, no gap and a pulse limit. The `limit_hit` output can be wired into the gate or kill inputs of a second instance, so that one generator controls another. All configuration inputs are captured only while the block is idle.

Top module: `burst_pulser`

## Requirements
- R1: Cycle 0 is the clock cycle that follows the rising edge at which the run condition is first seen true. The first pulse goes high in cycle `cfg_start_wait`, so a wait of 0 puts it in cycle 0.
- R2: Each pulse stays high for `cfg_width` consecutive cycles.
- R3: `cfg_gap` low cycles separate consecutive pulses. With a gap of 0, consecutive pulses join into one unbroken high stretch.
- R4: In single mode (`cfg_loop`=0) with `cfg_limit` nonzero, no pulse follows pulse number `cfg_limit`. `limit_hit` goes high in the cycle after that pulse's last high cycle, before any delay is applied. It stays high while the run condition holds. A limit of 0 means pulses never stop.
- R5: `pulse_out` follows the internal pulse train delayed by `cfg_delay` cycles, with a range of 0 to 15. `limit_hit` is not delayed.
- R6: In loop mode, after pulse number `cfg_limit` the sequence starts again from the startup wait. `limit_hit` is high for exactly one cycle each time this restart happens.
- R7: The run condition is `gate_in[cfg_gate_sel]` XOR `cfg_veto`. With `cfg_veto`=1 the selected input acts as a veto. Unselected gate inputs have no effect.
- R8: Suppose `cfg_kill_en`=1 and `kill_in[cfg_kill_sel]` is high during a cycle in which a pulse is high. That pulse then ends after that cycle. It counts toward the limit, and the gap follows it. The input has no effect outside pulses, when it is unselected, or when `cfg_kill_en`=0.
- R9: `hold_low` forces `pulse_out` low in the same cycle. It does not change the timing of later pulses.
- R10: A `cfg_width` of 0 gives no pulses, and the block stays idle.
- R11: If the run condition turns false, then from the next cycle `pulse_out` and `limit_hit` are low, including any pulses still inside the delay. The pulse count is cleared, and the next run starts again as in R1.
- R12: Configuration inputs changed while a sequence is running have no effect until the block is idle again.
- R13: After reset, `pulse_out` and `limit_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_start_wait | input | CNT_W | Cycles from start to the first pulse |
| cfg_width | input | CNT_W | Pulse width in cycles, 0 = no output |
| cfg_gap | input | CNT_W | Low cycles between pulses |
| cfg_limit | input | CNT_W | Pulses per sequence, 0 = unlimited |
| cfg_delay | input | DLY_W | Output delay in cycles |
| cfg_loop | input | 1 | 1 = restart the sequence after the limit |
| cfg_veto | input | 1 | 1 = selected gate input acts as a veto |
| cfg_gate_sel | input | SEL_W | Index of the gate input |
| cfg_kill_en | input | 1 | Enables the kill source |
| cfg_kill_sel | input | SEL_W | Index of the kill input |
| gate_in | input | NSRC | Candidate run-condition sources |
| kill_in | input | NSRC | Candidate kill sources |
| hold_low | input | 1 | Forces the output low |
| pulse_out | output | 1 | Delayed pulse train |
| limit_hit | output | 1 | Pulse limit reached |

## Verification
A corrupted cycle counter or state register shows up as a high stretch or gap of the wrong length. That error appears at `pulse_out` within one pulse period, plus the programmed delay. A pulse count that is wrong, or not cleared when a run is dropped, moves the rising edge of `limit_hit` by at least one whole pulse period. Because the bench compares both outputs in every cycle of a run, such faults are caught at the first cycle that differs. Faults in the delay line, or in capturing the configuration only while idle, show as pulses shifted or reshaped compared with the schedule computed from the configuration set at the start.

// File: rtl/burst_pulser.sv
module burst_pulser #(
  parameter int CNT_W = 16,
  parameter int NSRC  = 4,
  parameter int DLY_W = 4,
  localparam int SEL_W = $clog2(NSRC),
  localparam int DMAX  = (1 << DLY_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_start_wait,
  input  logic [CNT_W-1:0] cfg_width,
  input  logic [CNT_W-1:0] cfg_gap,
  input  logic [CNT_W-1:0] cfg_limit,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             cfg_loop,
  input  logic             cfg_veto,
  input  logic [SEL_W-1:0] cfg_gate_sel,
  input  logic             cfg_kill_en,
  input  logic [SEL_W-1:0] cfg_kill_sel,
  input  logic [NSRC-1:0]  gate_in,
  input  logic [NSRC-1:0]  kill_in,
  input  logic             hold_low,
  output logic             pulse_out,
  output logic             limit_hit
);

  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_PULSE, ST_GAP, ST_DONE} state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt, pcount;
  logic             wrap_q;
  logic [DMAX-1:0]  dline;

  logic [CNT_W-1:0] sh_start, sh_width, sh_gap, sh_limit;
  logic [DLY_W-1:0] sh_delay;
  logic             sh_loop, sh_veto, sh_kill_en;
  logic [SEL_W-1:0] sh_gate_sel, sh_kill_sel;

  wire idle = (st == ST_IDLE);

  wire [CNT_W-1:0] k_start    = idle ? cfg_start_wait : sh_start;
  wire [CNT_W-1:0] k_width    = idle ? cfg_width      : sh_width;
  wire [CNT_W-1:0] k_gap      = idle ? cfg_gap        : sh_gap;
  wire [CNT_W-1:0] k_limit    = idle ? cfg_limit      : sh_limit;
  wire [DLY_W-1:0] k_delay    = idle ? cfg_delay      : sh_delay;
  wire             k_loop     = idle ? cfg_loop       : sh_loop;
  wire             k_veto     = idle ? cfg_veto       : sh_veto;
  wire             k_kill_en  = idle ? cfg_kill_en    : sh_kill_en;
  wire [SEL_W-1:0] k_gate_sel = idle ? cfg_gate_sel   : sh_gate_sel;
  wire [SEL_W-1:0] k_kill_sel = idle ? cfg_kill_sel   : sh_kill_sel;

  wire run_ok = gate_in[k_gate_sel] ^ k_veto;
  wire kill   = k_kill_en & kill_in[k_kill_sel];

  wire [CNT_W-1:0] pcount_nx = pcount + 1'b1;
  wire             last      = (k_limit != '0) && (pcount_nx == k_limit);
  wire             raw       = (st == ST_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_start    <= '0;
      sh_width    <= '0;
      sh_gap      <= '0;
      sh_limit    <= '0;
      sh_delay    <= '0;
      sh_loop     <= 1'b0;
      sh_veto     <= 1'b0;
      sh_kill_en  <= 1'b0;
      sh_gate_sel <= '0;
      sh_kill_sel <= '0;
    end else if (idle) begin
      sh_start    <= cfg_start_wait;
      sh_width    <= cfg_width;
      sh_gap      <= cfg_gap;
      sh_limit    <= cfg_limit;
      sh_delay    <= cfg_delay;
      sh_loop     <= cfg_loop;
      sh_veto     <= cfg_veto;
      sh_kill_en  <= cfg_kill_en;
      sh_gate_sel <= cfg_gate_sel;
      sh_kill_sel <= cfg_kill_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      pcount <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (!run_ok) begin
        st     <= ST_IDLE;
        pcount <= '0;
      end else begin
        case (st)
          ST_IDLE: if (k_width != '0) begin
            pcount <= '0;
            if (k_start != '0) begin
              st  <= ST_WAIT;
              cnt <= k_start - 1'b1;
            end else begin
              st  <= ST_PULSE;
              cnt <= k_width - 1'b1;
            end
          end
          ST_WAIT: if (cnt == '0) begin
            st  <= ST_PULSE;
            cnt <= k_width - 1'b1;
          end else cnt <= cnt - 1'b1;
          ST_PULSE: if (cnt == '0 || kill) begin
            if (last) begin
              pcount <= '0;
              if (k_loop) begin
                wrap_q <= 1'b1;
                if (k_start != '0) begin
                  st  <= ST_WAIT;
                  cnt <= k_start - 1'b1;
                end else begin
                  st  <= ST_PULSE;
                  cnt <= k_width - 1'b1;
                end
              end else st <= ST_DONE;
            end else begin
              pcount <= pcount_nx;
              if (k_gap != '0) begin
                st  <= ST_GAP;
                cnt <= k_gap - 1'b1;
              end else cnt <= k_width - 1'b1;
            end
          end else cnt <= cnt - 1'b1;
          ST_GAP: if (cnt == '0) begin
            st  <= ST_PULSE;
            cnt <= k_width - 1'b1;
          end else cnt <= cnt - 1'b1;
          default: st <= ST_DONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dline <= '0;
    else if (!run_ok) dline <= '0;
    else              dline <= {dline[DMAX-2:0], raw};
  end

  wire delayed = (k_delay == '0) ? raw : dline[k_delay - 1'b1];

  assign pulse_out = delayed & ~hold_low;
  assign limit_hit = (st == ST_DONE) | wrap_q;

  assert_limit_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (k_limit != '0) |-> (pcount < k_limit));

  assert_done_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE && run_ok) |=> (st == ST_DONE));

  assert_first_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PULSE && $past(st) == ST_IDLE) |-> ($past(k_start) == '0));

  assert_zero_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && k_width == '0) |=> (st == ST_IDLE));

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> (st == ST_IDLE && pcount == '0));

  assert_loop_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> (st == ST_WAIT || st == ST_PULSE));

endmodule

// File: tb/burst_pulser_test.sv
module burst_pulser_test;
  localparam int CNT_W = 16;
  localparam int NSRC  = 4;
  localparam int DLY_W = 4;
  localparam int SEL_W = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] cfg_start_wait = '0, cfg_width = '0, cfg_gap = '0, cfg_limit = '0;
  logic [DLY_W-1:0] cfg_delay = '0;
  logic             cfg_loop = 1'b0, cfg_veto = 1'b0, cfg_kill_en = 1'b0;
  logic [SEL_W-1:0] cfg_gate_sel = '0, cfg_kill_sel = '0;
  logic [NSRC-1:0]  gate_in = '0, kill_in = '0;
  logic             hold_low = 1'b0;
  logic             pulse_out, limit_hit;

  burst_pulser #(.CNT_W(CNT_W), .NSRC(NSRC), .DLY_W(DLY_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_start_wait(cfg_start_wait), .cfg_width(cfg_width), .cfg_gap(cfg_gap),
    .cfg_limit(cfg_limit), .cfg_delay(cfg_delay), .cfg_loop(cfg_loop),
    .cfg_veto(cfg_veto), .cfg_gate_sel(cfg_gate_sel), .cfg_kill_en(cfg_kill_en),
    .cfg_kill_sel(cfg_kill_sel), .gate_in(gate_in), .kill_in(kill_in),
    .hold_low(hold_low), .pulse_out(pulse_out), .limit_hit(limit_hit)
  );

  always #10 clk = ~clk;

  int    compared = 0;
  int    mismatched = 0;
  int    cyc_idx = 0;
  bit    finished = 1'b0;
  string cur_tag = "";
  logic [1:0] expq[$];
  bit eo[0:127];
  bit em[0:127];

  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [1:0] it;
      it = expq.pop_front();
      compared++;
      if ({pulse_out, limit_hit} !== it) begin
        mismatched++;
        $display("FAIL %s cycle %0d: pulse_out=%0b limit_hit=%0b expected %0b %0b",
                 cur_tag, cyc_idx, pulse_out, limit_hit, it[1], it[0]);
      end
      cyc_idx++;
    end
  end

  task automatic run_case(input string tag, input int s, input int l, input int g,
                          input int lim, input int d, input bit lp, input bit vt,
                          input int gsel, input bit ken, input int ksel, input bit go,
                          input int n, input int kill_c, input int abort_c,
                          input int hold_c, input int chg_c);
    int t, k, e, nx, fz;
    for (int c = 0; c < n; c++) begin eo[c] = 1'b0; em[c] = 1'b0; end
    fz = ken ? kill_c : -1;
    if (go && l > 0) begin
      t = s; k = 0;
      while (t < n) begin
        e = t + l - 1;
        if (fz >= t && fz <= e) e = fz;
        for (int c = t; c <= e && c < n; c++) eo[c] = 1'b1;
        k++;
        nx = e + 1;
        if (lim != 0 && k == lim) begin
          if (lp) begin
            if (nx < n) em[nx] = 1'b1;
            k = 0;
            t = nx + s;
          end else begin
            for (int c = nx; c < n; c++) em[c] = 1'b1;
            break;
          end
        end else t = nx + g;
      end
    end
    for (int c = n - 1; c >= 0; c--) eo[c] = (c >= d) ? eo[c-d] : 1'b0;
    if (abort_c >= 0)
      for (int c = abort_c + 1; c < n; c++) begin eo[c] = 1'b0; em[c] = 1'b0; end
    if (hold_c >= 0) eo[hold_c] = 1'b0;

    @(posedge clk); #2;
    cfg_start_wait = CNT_W'(s); cfg_width = CNT_W'(l); cfg_gap = CNT_W'(g);
    cfg_limit = CNT_W'(lim); cfg_delay = DLY_W'(d); cfg_loop = lp; cfg_veto = vt;
    cfg_gate_sel = SEL_W'(gsel); cfg_kill_en = ken; cfg_kill_sel = SEL_W'(ksel);
    gate_in = '0; gate_in[gsel] = vt; kill_in = '0; hold_low = 1'b0;
    @(posedge clk); #2;
    gate_in[gsel] = go ? ~vt : vt;
    @(posedge clk); #1;
    cur_tag = tag;
    cyc_idx = 0;
    for (int c = 0; c < n; c++) expq.push_back({eo[c], em[c]});
    #1;
    for (int c = 0; c < n; c++) begin
      bit run_now;
      run_now = go && !(abort_c >= 0 && c >= abort_c);
      gate_in = c[0] ? '1 : '0;
      gate_in[gsel] = run_now ? ~vt : vt;
      kill_in = c[0] ? '1 : '0;
      kill_in[ksel] = (c == kill_c);
      hold_low = (c == hold_c);
      if (c == chg_c) begin cfg_width = 1; cfg_gap = 0; cfg_delay = 0; end
      @(posedge clk); #2;
    end
    gate_in = '0; gate_in[gsel] = vt; kill_in = '0; hold_low = 1'b0;
    repeat (3) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    compared++;
    if (pulse_out !== 1'b0 || limit_hit !== 1'b0) begin
      mismatched++;
      $display("FAIL R13 reset: pulse_out=%0b limit_hit=%0b expected 0 0", pulse_out, limit_hit);
    end
    //          tag                  s  l  g lim d lp vt gs ken ks go  n  kill abort hold chg
    run_case("R1 R2 R3 R4 basic",   3, 2, 4, 3,  0, 0, 0, 0, 0, 1, 1, 30, -1, -1, -1, -1);
    run_case("R1 R3 zero wait/gap", 0, 1, 0, 4,  0, 0, 0, 0, 0, 1, 1, 10, -1, -1, -1, -1);
    run_case("R5 delay 4",          2, 3, 1, 2,  4, 0, 0, 1, 0, 1, 1, 20, -1, -1, -1, -1);
    run_case("R5 delay 15",         0, 2, 2, 2, 15, 0, 0, 0, 0, 1, 1, 30, -1, -1, -1, -1);
    run_case("R6 loop",             2, 1, 1, 2,  0, 1, 0, 0, 0, 1, 1, 24, -1, -1, -1, -1);
    run_case("R4 unlimited",        1, 2, 1, 0,  0, 0, 0, 3, 0, 1, 1, 16, -1, -1, -1, -1);
    run_case("R7 veto input",       1, 2, 2, 2,  0, 0, 1, 2, 0, 1, 1, 12, -1, -1, -1, -1);
    run_case("R7 unselected gate",  1, 2, 2, 2,  0, 0, 0, 1, 0, 2, 0, 10, -1, -1, -1, -1);
    run_case("R8 kill",             1, 6, 2, 2,  0, 0, 0, 0, 1, 3, 1, 16,  3, -1, -1, -1);
    run_case("R8 kill disabled",    1, 6, 2, 2,  0, 0, 0, 0, 0, 3, 1, 18,  3, -1, -1, -1);
    run_case("R8 kill in gap",      1, 3, 3, 2,  0, 0, 0, 0, 1, 1, 1, 14,  5, -1, -1, -1);
    run_case("R9 hold_low",         1, 4, 1, 2,  0, 0, 0, 0, 0, 1, 1, 14, -1, -1,  2, -1);
    run_case("R10 zero width",      1, 0, 1, 2,  0, 0, 0, 0, 0, 1, 1, 10, -1, -1, -1, -1);
    run_case("R11 abort",           1, 3, 2, 3,  2, 0, 0, 0, 0, 1, 1, 14, -1,  6, -1, -1);
    run_case("R11 restart cleared", 1, 3, 2, 3,  2, 0, 0, 0, 0, 1, 1, 24, -1, -1, -1, -1);
    run_case("R12 config held",     1, 3, 2, 2,  1, 0, 0, 0, 0, 1, 1, 14, -1, -1, -1,  2);
    repeat (4) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule